// File: doc/BRIEF.md
# Multicycle Execute Stall Pipeline

This block is the control and datapath skeleton of a four-stage in-order pipeline: fetch, decode, execute and write. A small instruction array holds the program. Each instruction word carries a payload and a one-bit class tag. Ordinary instructions spend one cycle in each stage. A tagged long instruction, such as a divide, holds the execute stage for `LAT` cycles, which is three by default.

While execute is busy, the decode-to-execute buffer and the fetch-to-decode buffer both keep their contents. The program counter stops, so fetch and decode accept nothing new. The write stage receives bubbles instead of results. Results are never queued. Every instruction reaches write once, in program order, and a writeback strobe marks each completion.

The program is loaded through a simple write port. Fetching then runs while `run` is high and the program counter is below `prog_len`. Per-cycle stage occupancy is brought out so that the stall pattern can be observed.

Top module: `mc_pipe`

## Requirements
- R1: After reset, all four occupancy bits and `wb_valid` are 0, and both buffers are invalid.
- R2: With only ordinary instructions (tag bit `ld_data[IW]` = 0), instruction k (counting from 0) writes back on the clock edge 3+k after `run` is raised, one instruction per cycle.
- R3: A long instruction (tag bit `ld_data[IW]` = 1) stays in execute for `LAT` cycles. It delays its own writeback, and every later one, by `LAT`-1 cycles.
- R4: During the extra execute cycles of a long instruction, `wb_valid` is 0, so each stall cycle becomes exactly one write bubble.
- R5: During a stall, the decode-to-execute buffer, the fetch-to-decode buffer and the program counter hold their values. Fetch reports no acceptance: `stage_occ[0]` = 0.
- R6: Payloads appear on `wb_data` in program order, each exactly once.
- R7: Invalid buffer entries never produce a writeback. With `prog_len` = 0, or after the program drains, `wb_valid` and all occupancy bits stay 0.
- R8: Back-to-back long instructions each add `LAT`-1 cycles, with no extra gap between them.
- R9: `stage_occ` bit 0 is fetch accepting, bit 1 is decode holding a valid entry, bit 2 is execute holding a valid entry, and bit 3 is write completing (equal to `wb_valid`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Instruction array write enable |
| ld_addr | input | AW | Instruction array write address |
| ld_data | input | IW+1 | Instruction word; bit IW is the long tag |
| run | input | 1 | Allows fetch |
| prog_len | input | AW+1 | Number of instructions to fetch |
| stage_occ | output | 4 | Per-stage occupancy: {write, execute, decode, fetch} |
| wb_valid | output | 1 | Writeback strobe |
| wb_data | output | IW | Payload of the completing instruction |

## Verification
An all-ordinary program sets the baseline of one completion per cycle with a fixed three-edge latency. A single long instruction in the middle of ordinary ones shows the stall length, the bubble placement, and the frozen fetch in the occupancy bits. A program that starts with two long instructions back to back separates a correct reload of the stall counter from one that adds or drops a cycle between them. An empty program shows that invalid entries stay silent. A scoreboard compares every payload and its completion edge against values computed from the tags.

// File: rtl/mc_pipe.sv
module mc_pipe #(
  parameter int IW    = 8,
  parameter int DEPTH = 16,
  parameter int LAT   = 3,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(LAT) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [IW:0]   ld_data,
  input  logic          run,
  input  logic [AW:0]   prog_len,
  output logic [3:0]    stage_occ,
  output logic          wb_valid,
  output logic [IW-1:0] wb_data
);

  logic [IW:0]   imem [DEPTH];
  logic [AW:0]   pc;
  logic          b1_v, b2_v, wb_v;
  logic [IW:0]   b1_d, b2_d;
  logic [IW-1:0] wb_d;
  logic [CW-1:0] cnt;

  wire stall    = cnt != '0;
  wire fetch_go = run && (pc < prog_len) && !stall;

  always_ff @(posedge clk)
    if (ld_en) imem[ld_addr] <= ld_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc   <= '0;
      b1_v <= 1'b0;
      b2_v <= 1'b0;
      wb_v <= 1'b0;
      b1_d <= '0;
      b2_d <= '0;
      wb_d <= '0;
      cnt  <= '0;
    end else begin
      if (!stall) begin
        b1_v <= fetch_go;
        if (fetch_go) begin
          b1_d <= imem[pc[AW-1:0]];
          pc   <= pc + 1'b1;
        end
        b2_v <= b1_v;
        b2_d <= b1_d;
        cnt  <= (b1_v && b1_d[IW]) ? CW'(LAT - 1) : '0;
      end else begin
        cnt <= cnt - 1'b1;
      end
      wb_v <= b2_v && !stall;
      wb_d <= b2_d[IW-1:0];
    end
  end

  assign stage_occ = {wb_v, b2_v, b1_v, fetch_go};
  assign wb_valid  = wb_v;
  assign wb_data   = wb_d;

  p_b2_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(b2_v) && $stable(b2_d));

  p_b1_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(b1_v) && $stable(b1_d) && $stable(pc));

  p_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !wb_valid);

  p_long_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> b2_v && b2_d[IW]);

  p_no_ghost_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !b2_v |=> !wb_valid);

  p_complete_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (b2_v && !stall) |=> wb_valid && (wb_data == $past(b2_d[IW-1:0])));

endmodule

// File: tb/mc_pipe_test.sv
module mc_pipe_test;
  localparam int IW = 8, DEPTH = 16, LAT = 3, AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, ld_en = 0, run = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [IW:0]   ld_data = '0;
  logic [AW:0]   prog_len = '0;
  logic [3:0]    stage_occ;
  logic          wb_valid;
  logic [IW-1:0] wb_data;

  mc_pipe #(.IW(IW), .DEPTH(DEPTH), .LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .run(run), .prog_len(prog_len), .stage_occ(stage_occ), .wb_valid(wb_valid),
    .wb_data(wb_data));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, start = 0;
  bit active = 0, finished = 0;
  bit          p_long [DEPTH];
  logic [IW-1:0] p_pay [DEPTH];
  int          q_edge [$];
  logic [IW-1:0] q_pay [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (active && wb_valid) begin
      if (q_pay.size() == 0) chk(0, "R7 unexpected writeback", int'(wb_data), -1);
      else begin
        int e; logic [IW-1:0] p;
        e = q_edge.pop_front();
        p = q_pay.pop_front();
        chk(wb_data == p, "R6 payload order", int'(wb_data), int'(p));
        chk(cyc - start == e, "R2/R3 writeback edge", cyc - start, e);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0; run = 0;
    repeat (2) @(negedge clk);
    chk(stage_occ == 4'b0 && !wb_valid, "R1 reset state", int'({stage_occ, wb_valid}), 0);
    rst_n = 1;
  endtask

  task automatic load(input int i, input bit l, input logic [IW-1:0] p);
    @(negedge clk);
    ld_en = 1; ld_addr = AW'(i); ld_data = {l, p};
    p_long[i] = l; p_pay[i] = p;
    @(negedge clk); ld_en = 0;
  endtask

  task automatic go_start(input int n);
    int longs = 0;
    @(negedge clk);
    prog_len = (AW+1)'(n);
    for (int i = 0; i < n; i++) begin
      if (p_long[i]) longs++;
      q_edge.push_back(3 + i + (LAT - 1) * longs);
      q_pay.push_back(p_pay[i]);
    end
    run = 1; start = cyc; active = 1;
  endtask

  task automatic go_finish(input int n);
    repeat (n * LAT + 8) @(negedge clk);
    chk(q_pay.size() == 0, "R6 all written once", q_pay.size(), 0);
    chk(stage_occ == 4'b0 && !wb_valid, "R7 drained silent", int'(stage_occ), 0);
    run = 0; active = 0;
    q_pay.delete(); q_edge.delete();
  endtask

  initial begin
    do_reset();
    // Program 1: ordinary, long, then ordinary
    load(0, 0, 8'h11); load(1, 1, 8'h22); load(2, 0, 8'h33); load(3, 0, 8'h44); load(4, 0, 8'h55);
    go_start(5);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(stage_occ == 4'b1110, "R5 R9 stall cycle 1 occupancy", int'(stage_occ), 4'b1110);
    @(negedge clk);
    chk(stage_occ == 4'b0110, "R4 R5 stall cycle 2 bubble", int'(stage_occ), 4'b0110);
    @(negedge clk);
    chk(stage_occ == 4'b0111, "R3 R4 release cycle", int'(stage_occ), 4'b0111);
    @(negedge clk);
    chk(stage_occ == 4'b1111, "R9 full pipe after stall", int'(stage_occ), 4'b1111);
    go_finish(5);

    // Program 2: all ordinary
    do_reset();
    for (int i = 0; i < 6; i++) load(i, 0, IW'(8'hA0 + i));
    go_start(6);
    repeat (4) @(negedge clk);
    chk(stage_occ == 4'b1111, "R2 R9 steady flow", int'(stage_occ), 4'b1111);
    go_finish(6);

    // Program 3: back-to-back long at start (R8)
    do_reset();
    load(0, 1, 8'hC1); load(1, 1, 8'hC2); load(2, 0, 8'hC3); load(3, 1, 8'hC4); load(4, 0, 8'hC5);
    go_start(5);
    go_finish(5);

    // Program 4: empty program
    do_reset();
    go_start(0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(stage_occ == 4'b0 && !wb_valid, "R7 empty program", int'(stage_occ), 0);
    end
    go_finish(0);

    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule